// File: doc/BRIEF.md
# Shared Stream Router for a Two-Way Split State Machine

When a streaming state machine is cut into two partitions, only one partition runs at a time, yet both may read the same input stream and write the same output stream. This block sits between the shared streams and the two partitions. On the input side it routes every upstream token to the partitions. On the output side it merges what the partitions produce into one downstream stream. Token order matches what a single unsplit machine would give.

The block learns which partition is running by snooping the activation handshake: the running partition passes control to the idle one, and the idle one waits for it. The mode is chosen once, at reset.

- **Broadcast mode.** Every token goes to both partitions. The upstream side advances only after both have taken it. The idle partition drops its copies by counting them.
- **Request mode.** A token goes only to the running partition, and only after that partition has asked for it with a request pulse. A small credit counter lets a partition ask ahead.

On the output side, only the running partition's result stream reaches downstream.

Top module: `shared_stream_router`

## Requirements
- R1: After reset, partition 0 is the running partition. A completed handshake on the running partition's activation channel (`act_valid[i]` and `act_ready[i]` both high at a clock edge, `i` being the running partition) makes the other partition the running one from the next cycle on.
- R2: In broadcast mode (`mode_bcast` = 1), every upstream token is presented to both partitions with the same data. `in_ready` is high only once each partition has taken the token, either in that cycle or in an earlier one.
- R3: In broadcast mode, a partition that has already taken the current token does not see it presented again. Its next transfer is the following token.
- R4: In request mode (`mode_bcast` = 0), each request pulse from the running partition adds one credit, up to REQ_MAX credits. A token is presented to the running partition only while it holds a credit. Each delivered token spends one credit.
- R5: In request mode, the idle partition's request and ready inputs have no effect, and its `part_valid` bit stays 0.
- R6: A change of running partition clears all credits. The new running partition receives nothing until it issues its own request.
- R7: `out_valid` and `out_data` follow the running partition's result stream. `res_ready` of the running partition equals `out_ready`. `res_ready` of the idle partition is 0.
- R8: In either mode, the sequence on the downstream stream equals the sequence a single unsplit machine would produce from the same input tokens, under any pattern of backpressure.
- R9: While reset is held and just after it is released, `out_valid` is 0 as long as the partitions hold no results, and nothing moves upstream or to either partition until a partition is ready or has requested a token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bcast | input | 1 | 1 = broadcast mode, 0 = request mode; held static after reset |
| in_valid | input | 1 | Upstream token valid |
| in_data | input | DATA_W | Upstream token data |
| in_ready | output | 1 | Upstream token accepted |
| part_valid | output | 2 | Token presented to partition i (bit i) |
| part_data | output | 2*DATA_W | Token data per partition, partition i in slice i |
| part_ready | input | 2 | Partition i takes the presented token |
| part_req | input | 2 | Request pulse per partition (request mode) |
| act_valid | input | 2 | Snooped activation token from partition i |
| act_ready | input | 2 | Snooped acceptance of partition i's activation token |
| res_valid | input | 2 | Result valid from partition i |
| res_data | input | 2*DATA_W | Result data per partition, partition i in slice i |
| res_ready | output | 2 | Result accepted from partition i |
| out_valid | output | 1 | Downstream result valid |
| out_data | output | DATA_W | Downstream result data |
| out_ready | input | 1 | Downstream accepts the result |

## Verification
The assertions rely on these input assumptions:

- Only the running partition ever raises its activation valid.
- Request pulses are counted only from the running partition.
- `mode_bcast` stays constant between resets.
- The upstream source holds its token until it is accepted.

The bench models both partitions from one shared schedule. The activation valid is driven only for the partition the schedule marks as running. Upstream data is held until its handshake. The mode is changed only while reset is asserted.

Within those limits, the bench still sends stray requests and stray ready from the idle partition and garbage results from it. This shows those inputs are ignored.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int NPART = 2;
   typedef logic part_t;
endpackage

// File: rtl/ssr_active_tracker.sv
module ssr_active_tracker
   import ssr_pkg::*;
#(
   parameter int INIT_PART = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPART-1:0] act_valid,
   input  logic [NPART-1:0] act_ready,
   output part_t            active_o,
   output logic             switch_o
);
   part_t active_q;

   always_comb switch_o = act_valid[active_q] & act_ready[active_q];

   always_ff @(posedge clk) begin
      if (!rst_n)        active_q <= part_t'(INIT_PART);
      else if (switch_o) active_q <= ~active_q;
   end

   assign active_o = active_q;

   a_r1_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      switch_o |=> (active_q != $past(active_q)));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !switch_o |=> $stable(active_q));
endmodule

// File: rtl/ssr_distributor.sv
module ssr_distributor
   import ssr_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int REQ_MAX = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_bcast,
   input  part_t                   active_i,
   input  logic                    switch_i,
   input  logic                    in_valid,
   input  logic [DATA_W-1:0]       in_data,
   output logic                    in_ready,
   output logic [NPART-1:0]        part_valid,
   output logic [NPART*DATA_W-1:0] part_data,
   input  logic [NPART-1:0]        part_ready,
   input  logic [NPART-1:0]        part_req
);
   localparam int CRD_W = $clog2(REQ_MAX + 1);

   logic [NPART-1:0] taken_q;
   logic [NPART-1:0] lane_pass;
   logic [CRD_W-1:0] credit_q;
   logic             has_credit;
   logic             up_fire;
   logic             req_ok;
   logic             spend;

   assign has_credit = (credit_q != '0);
   assign up_fire    = in_valid & in_ready;

   for (genvar i = 0; i < NPART; i++) begin : g_lane
      assign part_data[i*DATA_W +: DATA_W] = in_data;
      assign lane_pass[i] = taken_q[i] | part_ready[i];

      always_comb begin
         if (mode_bcast) part_valid[i] = in_valid & ~taken_q[i];
         else            part_valid[i] = in_valid & has_credit & (active_i == part_t'(i));
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                             taken_q[i] <= 1'b0;
         else if (!mode_bcast || up_fire)        taken_q[i] <= 1'b0;
         else if (part_valid[i] && part_ready[i]) taken_q[i] <= 1'b1;
      end

      a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
         mode_bcast && part_valid[i] && part_ready[i] && !up_fire |=> !part_valid[i]);
   end

   always_comb begin
      if (mode_bcast) in_ready = &lane_pass;
      else            in_ready = has_credit & part_ready[active_i];
   end

   assign req_ok = ~mode_bcast & part_req[active_i] & (credit_q < CRD_W'(REQ_MAX));
   assign spend  = ~mode_bcast & up_fire;

   always_ff @(posedge clk) begin
      if (!rst_n || switch_i) credit_q <= '0;
      else                    credit_q <= credit_q + CRD_W'(req_ok) - CRD_W'(spend);
   end

   a_r2_join: assert property (@(posedge clk) disable iff (!rst_n)
      mode_bcast && up_fire |-> &(taken_q | (part_valid & part_ready)));
   a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
      credit_q <= CRD_W'(REQ_MAX));
   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_bcast |-> !part_valid[~active_i]);
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      switch_i |=> (credit_q == '0));
endmodule

// File: rtl/ssr_collector.sv
module ssr_collector
   import ssr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  part_t                   active_i,
   input  logic [NPART-1:0]        res_valid,
   input  logic [NPART*DATA_W-1:0] res_data,
   output logic [NPART-1:0]        res_ready,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   input  logic                    out_ready
);
   for (genvar i = 0; i < NPART; i++) begin : g_sel
      assign res_ready[i] = out_ready & (active_i == part_t'(i));
   end

   assign out_valid = res_valid[active_i];
   assign out_data  = res_data[active_i*DATA_W +: DATA_W];

   a_r7_single_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_ready));
   a_r7_idle_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !res_ready[~active_i]);
endmodule

// File: rtl/shared_stream_router.sv
module shared_stream_router
   import ssr_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REQ_MAX   = 2,
   parameter int INIT_PART = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_bcast,
   input  logic                    in_valid,
   input  logic [DATA_W-1:0]       in_data,
   output logic                    in_ready,
   output logic [1:0]              part_valid,
   output logic [2*DATA_W-1:0]     part_data,
   input  logic [1:0]              part_ready,
   input  logic [1:0]              part_req,
   input  logic [1:0]              act_valid,
   input  logic [1:0]              act_ready,
   input  logic [1:0]              res_valid,
   input  logic [2*DATA_W-1:0]     res_data,
   output logic [1:0]              res_ready,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   input  logic                    out_ready
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (REQ_MAX < 1) begin : g_bad_credit
      $error("REQ_MAX must be at least 1");
   end
   if (INIT_PART < 0 || INIT_PART >= NPART) begin : g_bad_init
      $error("INIT_PART must name one of the two partitions");
   end

   part_t active;
   logic  switch_evt;

   ssr_active_tracker #(.INIT_PART(INIT_PART)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_valid (act_valid),
      .act_ready (act_ready),
      .active_o  (active),
      .switch_o  (switch_evt)
   );

   ssr_distributor #(.DATA_W(DATA_W), .REQ_MAX(REQ_MAX)) u_dist (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_bcast (mode_bcast),
      .active_i   (active),
      .switch_i   (switch_evt),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .part_valid (part_valid),
      .part_data  (part_data),
      .part_ready (part_ready),
      .part_req   (part_req)
   );

   ssr_collector #(.DATA_W(DATA_W)) u_coll (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_ready (res_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready)
   );

   a_r9_no_spurious_up: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (part_valid == 2'b00));
endmodule

// File: tb/shared_stream_router_tb_top.sv
`timescale 1ns/100ps
module shared_stream_router_tb_top;
   localparam int W     = 8;
   localparam int NSTEP = 30;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_bcast = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ready;
   logic [1:0]   part_valid;
   logic [2*W-1:0] part_data;
   logic [1:0]   part_ready = '0;
   logic [1:0]   part_req = '0;
   logic [1:0]   act_valid = '0;
   logic [1:0]   act_ready = '0;
   logic [1:0]   res_valid = '0;
   logic [2*W-1:0] res_data = '0;
   logic [1:0]   res_ready;
   logic         out_valid;
   logic [W-1:0] out_data;
   logic         out_ready = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit timed_out = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   shared_stream_router #(.DATA_W(W), .REQ_MAX(2), .INIT_PART(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_bcast(mode_bcast),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .part_valid(part_valid), .part_data(part_data), .part_ready(part_ready),
      .part_req(part_req), .act_valid(act_valid), .act_ready(act_ready),
      .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   function automatic logic [W-1:0] tok(input int k);
      return W'((k * 37 + 11) & 255);
   endfunction
   function automatic logic [W-1:0] xf(input logic [W-1:0] x);
      return x ^ 8'h5A;
   endfunction
   function automatic int nstep(input int s);
      return (s * 7 + 3) % 5;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic run_mode(input bit bc);
      int step, p, o, cons, emit, base, dc, outst, src_idx, total, out_cnt, n;
      bit src_v, stray;
      int lane_idx [2];
      bit req_cnt;
      rst_n = 1'b0; mode_bcast = bc;
      in_valid = 0; part_ready = 0; part_req = 0; act_valid = 0; act_ready = 0;
      res_valid = 0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      // R9: quiet during reset
      chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
      chk(part_valid == 2'b00, "R9 part_valid in reset", part_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(in_ready == 1'b0, "R9 in_ready after reset", in_ready, 0);
      // R1: partition 0 runs after reset
      chk(res_ready == 2'b01, "R1 initial running partition", res_ready, 1);
      total = 0;
      for (int s = 0; s < NSTEP; s++) total += nstep(s);
      step = 0; p = 0; cons = 0; emit = 0; base = 0; outst = 0;
      src_idx = 0; src_v = 0; out_cnt = 0; stray = 0;
      lane_idx[0] = 0; lane_idx[1] = 0;
      dc = bc ? nstep(0) : 0;
      while (step < NSTEP) begin
         if (cyc > 150000) begin timed_out = 1'b1; break; end
         @(negedge clk);
         n = nstep(step); o = 1 - p;
         if (!src_v && src_idx < total && $urandom_range(0, 3) != 0) src_v = 1'b1;
         in_valid = src_v; in_data = tok(src_idx);
         part_ready[p] = (cons < n) && ($urandom_range(0, 2) != 0);
         part_ready[o] = bc ? ((dc > 0) && ($urandom_range(0, 2) != 0)) : 1'($urandom_range(0, 1));
         part_req = '0;
         req_cnt = 1'b0;
         if (!bc) begin
            if (cons + outst < n && outst < 2 && $urandom_range(0, 1) == 1) begin
               part_req[p] = 1'b1; req_cnt = 1'b1;
            end
            part_req[o] = 1'($urandom_range(0, 1));
         end
         res_valid[p] = (emit < cons);
         res_data[p*W +: W] = xf(tok(base + emit));
         res_valid[o] = 1'($urandom_range(0, 1));
         res_data[o*W +: W] = 8'hC3;
         act_valid = '0;
         act_valid[p] = (cons == n) && (emit == n);
         act_ready = 2'($urandom_range(0, 3));
         if (!bc && act_valid[p] && step % 3 == 0) begin
            part_req[p] = 1'b1; stray = 1'b1;
         end
         out_ready = ($urandom_range(0, 3) != 0);
         #1;
         // R7: collector follows running partition
         chk(res_ready[o] == 1'b0, "R7 idle res_ready", res_ready[o], 0);
         chk(res_ready[p] == out_ready, "R7 running res_ready", res_ready[p], out_ready);
         chk(out_valid == res_valid[p], "R1/R7 out_valid source", out_valid, res_valid[p]);
         if (!bc) begin
            chk(part_valid[o] == 1'b0, "R5 idle part_valid", part_valid[o], 0);
            if (!stray) chk(!(part_valid[p] && outst == 0), "R4/R6 valid without credit", part_valid[p], 0);
         end
         for (int i = 0; i < 2; i++) begin
            if (part_valid[i] && part_ready[i]) begin
               if (bc) begin
                  chk(part_data[i*W +: W] == tok(lane_idx[i]), "R2/R3 lane data",
                      part_data[i*W +: W], tok(lane_idx[i]));
                  lane_idx[i]++;
                  if (i == p) cons++; else dc--;
               end else if (i == p) begin
                  chk(part_data[i*W +: W] == tok(base + cons), "R4 delivered data",
                      part_data[i*W +: W], tok(base + cons));
                  cons++; outst--;
               end
            end
         end
         if (in_valid && in_ready) begin
            if (bc) chk(lane_idx[0] == src_idx + 1 && lane_idx[1] == src_idx + 1,
                        "R2 upstream waits for both", lane_idx[0] + lane_idx[1], 2 * src_idx + 2);
            else chk(base + cons == src_idx + 1, "R4 upstream matches delivery", base + cons, src_idx + 1);
            src_idx++; src_v = 1'b0;
         end
         if (req_cnt) outst++;
         if (out_valid && out_ready) begin
            chk(out_data == xf(tok(out_cnt)), "R8 downstream order", out_data, xf(tok(out_cnt)));
            out_cnt++; emit++;
         end
         if (act_valid[p] && act_ready[p]) begin
            step++; base += n; p = o; cons = 0; emit = 0; outst = 0; stray = 0;
            dc = (bc && step < NSTEP) ? nstep(step) : 0;
         end
      end
      chk(out_cnt == total, "R8 all results collected", out_cnt, total);
      chk(src_idx == total, "R8 all tokens consumed", src_idx, total);
   endtask

   initial begin
      run_mode(1'b1);
      if (!timed_out) run_mode(1'b0);
      if (timed_out) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      $display("FAIL watchdog hard stop actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
      $finish;
   end
endmodule